// File: doc/BRIEF.md
# Chained Two-Channel Timer Block

This block holds three 16-bit timer channels that share one master clock. Each channel picks its count pulse from a free-running prescaler (master clock divided by 2, 8, 32 or 128), from a slow-clock tick, or from an external input. Channel 0 drives a square wave that goes high each time its count wraps to zero. When the chaining bit is set, channel 1 takes the rising edges of that wave as its external input. Channel 1 then counts the wraps of channel 0, and the pair forms a free-running 32-bit counter: channel 1 holds the upper half and channel 0 the lower half.

Software programs the block through a simple write bus. A block-wide restart bit clears every channel in the same cycle. The combined value is exposed directly. Because the upper half advances one cycle after the lower half wraps, a reader samples the upper half, then the lower half, then the upper half again, and retries if the two upper samples differ. A build parameter selects a wide variant in which channel 0 alone is a 32-bit counter and channel 1 is idle.

Top module: `chained_timer32`

## Requirements
- R1: After reset all counts are zero, the wave output is low, every channel is disabled, every clock select is 0 and chaining is off.
- R2: The clock select field of the channel mode register (address 0, 1 or 2 for channel 0, 1 or 2; write data bits [2:0]) picks the count pulse. Code 0 selects a pulse in every cycle where prescaler bit 0 is set, code 1 where the prescaler's low 3 bits are all ones, code 2 where the low 5 bits are all ones and code 3 where all 7 bits are all ones. Code 4 selects slow_tick, code 5 selects the external input (the chained wave for channel 1, nothing for channels 0 and 2), and codes 6 and 7 select no pulse. The 7-bit prescaler counts up in every cycle from reset.
- R3: An enabled channel adds one on each selected pulse and wraps from all-ones to zero. A disabled channel holds its count. The enable register is at address 3, with bit n enabling channel n.
- R4: The wave output tioa0 rises on the channel 0 pulse that wraps the count to zero, and falls on the pulse that brings the count to half its range.
- R5: With chaining on (address 4, bit 0) and channel 1 on code 5, channel 1 advances exactly once per rising edge of tioa0, one cycle after that edge. With chaining off, channel 1 on code 5 holds.
- R6: Writing bit 0 at address 5 clears all counts and drives tioa0 low at the next edge. The clear wins over a pulse in the same cycle and leaves the prescaler running.
- R7: In the narrow variant, count_all equals the channel 1 count in the upper half and the channel 0 count in the lower half.
- R8: In the wide variant (WIDE=1), channel 0 counts over 2*CW bits, count_all equals cnt0, and cnt1 stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cnt0 | output | 2*CW | Channel 0 count (upper half zero when narrow) |
| cnt1 | output | CW | Channel 1 count |
| cnt2 | output | CW | Channel 2 count |
| tioa0 | output | 1 | Channel 0 wave output |
| count_all | output | 2*CW | Combined counter value |

## Verification
The bench builds the block twice. The first instance is the narrow variant with CW=8, so channel 0 wraps after 256 pulses. Several wraps, the chained advance of channel 1 and the half-range fall of tioa0 then fit in a few thousand cycles. The second instance is the wide variant with CW=8, driven with the same stimulus, so its channel 0 count carries past bit 7 where the narrow one wraps, while its channel 1 stays idle.

// File: rtl/chained_timer32.sv
module chained_timer32 #(
  parameter int CW   = 16,
  parameter int WIDE = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic [2*CW-1:0] cnt0,
  output logic [CW-1:0]   cnt1,
  output logic [CW-1:0]   cnt2,
  output logic            tioa0,
  output logic [2*CW-1:0] count_all
);
  localparam int C0W = (WIDE != 0) ? 2*CW : CW;
  localparam logic [C0W-1:0] HALF_M1 = {1'b0, {(C0W-1){1'b1}}};

  logic [6:0]     pre;
  logic [2:0]     sel0, sel1, sel2;
  logic [2:0]     en;
  logic           chain;
  logic [C0W-1:0] c0;
  logic [CW-1:0]  c1, c2;
  logic           wave, wave_q;

  wire sync_w  = wr_en && wr_addr == 3'd5 && wr_data[0];
  wire xc1     = chain && wave && !wave_q;

  function automatic logic pick(input logic [2:0] s, input logic [6:0] p,
                                input logic slow, input logic ext);
    case (s)
      3'd0:    pick = p[0];
      3'd1:    pick = &p[2:0];
      3'd2:    pick = &p[4:0];
      3'd3:    pick = &p;
      3'd4:    pick = slow;
      3'd5:    pick = ext;
      default: pick = 1'b0;
    endcase
  endfunction

  wire t0 = en[0] && pick(sel0, pre, slow_tick, 1'b0);
  wire t1 = en[1] && pick(sel1, pre, slow_tick, xc1) && (WIDE == 0);
  wire t2 = en[2] && pick(sel2, pre, slow_tick, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      sel0  <= '0;
      sel1  <= '0;
      sel2  <= '0;
      en    <= '0;
      chain <= 1'b0;
    end else begin
      pre <= pre + 7'd1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: sel0  <= wr_data[2:0];
          3'd1: sel1  <= wr_data[2:0];
          3'd2: sel2  <= wr_data[2:0];
          3'd3: en    <= wr_data[2:0];
          3'd4: chain <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0     <= '0;
      wave   <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      wave_q <= wave;
      if (sync_w) begin
        c0   <= '0;
        wave <= 1'b0;
      end else if (t0) begin
        c0 <= c0 + 1'b1;
        if (&c0)
          wave <= 1'b1;
        else if (c0 == HALF_M1)
          wave <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0;
      c2 <= '0;
    end else if (sync_w) begin
      c1 <= '0;
      c2 <= '0;
    end else begin
      if (t1) c1 <= c1 + 1'b1;
      if (t2) c2 <= c2 + 1'b1;
    end
  end

  generate
    if (WIDE != 0) begin : g_wide
      assign cnt0      = c0;
      assign count_all = c0;
    end else begin : g_chain
      assign cnt0      = {{CW{1'b0}}, c0};
      assign count_all = {c1, c0};
    end
  endgenerate

  assign cnt1  = c1;
  assign cnt2  = c2;
  assign tioa0 = wave;
endmodule

module chained_timer32_chk #(
  parameter int CW   = 16,
  parameter int WIDE = 0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic [7:0]      wr_data,
  input logic [2*CW-1:0] cnt0,
  input logic [CW-1:0]   cnt2,
  input logic            tioa0
);
  localparam int C0W = (WIDE != 0) ? 2*CW : CW;
  localparam logic [2*CW-1:0] HALF = (2*CW)'(1) << (C0W-1);
  wire sync_now = wr_en && wr_addr == 3'd5 && wr_data[0];

  // R6
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_now |=> (cnt0 == '0 && cnt2 == '0 && !tioa0));

  // R4
  wave_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tioa0) |-> cnt0 == '0);

  // R4
  wave_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tioa0) && !$past(sync_now)) |-> cnt0 == HALF);

  // R3
  ch2_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt2 != $past(cnt2)) |-> (cnt2 == $past(cnt2) + CW'(1) || cnt2 == '0));
endmodule

bind chained_timer32 chained_timer32_chk #(.CW(CW), .WIDE(WIDE)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .cnt0(cnt0), .cnt2(cnt2), .tioa0(tioa0)
);

// File: tb/chained_timer32_test.sv
module chained_timer32_test;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2*CW-1:0] cnt0, count_all, w_cnt0, w_all;
  logic [CW-1:0] cnt1, cnt2, w_cnt1, w_cnt2;
  logic tioa0, w_tioa0;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chained_timer32 #(.CW(CW), .WIDE(0)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cnt0(cnt0), .cnt1(cnt1),
    .cnt2(cnt2), .tioa0(tioa0), .count_all(count_all));

  chained_timer32 #(.CW(CW), .WIDE(1)) uut_w (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cnt0(w_cnt0), .cnt1(w_cnt1),
    .cnt2(w_cnt2), .tioa0(w_tioa0), .count_all(w_all));

  // behavioural reference
  int pc, m0, m1, m2, m0w, msel[3], men, mchain;
  bit mw, mwq;

  function automatic bit mtick(int s, int p, bit slow, bit ext);
    case (s)
      0: return (p % 2) == 1;
      1: return (p % 8) == 7;
      2: return (p % 32) == 31;
      3: return (p % 128) == 127;
      4: return slow;
      5: return ext;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc = 0; m0 = 0; m1 = 0; m2 = 0; m0w = 0; men = 0; mchain = 0;
      mw = 0; mwq = 0;
      for (int i = 0; i < 3; i++) msel[i] = 0;
    end else begin
      bit e1, k0, k1, k2, old_w, syn;
      e1 = mchain != 0 && mw && !mwq;
      k0 = men[0] && mtick(msel[0], pc % 128, slow_tick, 0);
      k1 = men[1] && mtick(msel[1], pc % 128, slow_tick, e1);
      k2 = men[2] && mtick(msel[2], pc % 128, slow_tick, 0);
      syn = wr_en && wr_addr == 5 && wr_data[0];
      old_w = mw;
      if (syn) begin
        m0 = 0; m1 = 0; m2 = 0; m0w = 0; mw = 0;
      end else begin
        if (k0) begin
          if (m0 == 255) mw = 1;
          else if (m0 == 127) mw = 0;
          m0 = (m0 + 1) % 256;
          m0w = (m0w + 1) % 65536;
        end
        if (k1) m1 = (m1 + 1) % 256;
        if (k2) m2 = (m2 + 1) % 256;
      end
      mwq = old_w;
      if (wr_en) begin
        if (wr_addr <= 2) msel[wr_addr] = wr_data[2:0];
        else if (wr_addr == 3) men = wr_data[2:0];
        else if (wr_addr == 4) mchain = wr_data[0];
      end
      pc++;
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cnt0 == 16'(m0), "R2/R3 cnt0", cnt0, m0);
      check(cnt1 == 8'(m1), "R5 cnt1", cnt1, m1);
      check(cnt2 == 8'(m2), "R2/R3 cnt2", cnt2, m2);
      check(tioa0 == mw, "R4 tioa0", tioa0, mw);
      check(count_all == 16'(m1 * 256 + m0), "R7 count_all", count_all, m1 * 256 + m0);
      check(w_cnt0 == 16'(m0w), "R8 wide cnt0", w_cnt0, m0w);
      check(w_all == 16'(m0w), "R8 wide count_all", w_all, m0w);
      check(w_cnt1 == 0, "R8 wide cnt1", w_cnt1, 0);
    end
  end

  int sc = 0;
  always @(negedge clk) begin
    sc = (sc + 1) % 7;
    slow_tick = (sc == 0);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1
    check(cnt0 == 0 && cnt1 == 0 && cnt2 == 0 && count_all == 0, "R1 counts", count_all, 0);
    check(tioa0 == 0, "R1 tioa0", tioa0, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    check(cnt0 == 0 && cnt2 == 0, "R1 disabled after reset", cnt0, 0);
    // R2 R5: chain ch1 off ch0 at /2, ch2 at /8
    wr(0, 0); wr(1, 5); wr(2, 1); wr(4, 1); wr(3, 7); wr(5, 1);
    check(cnt0 == 0 && cnt1 == 0 && cnt2 == 0, "R6 sync clears", cnt0, 0);
    repeat (3000) @(negedge clk);
    check(cnt1 >= 5, "R5 chained wraps", cnt1, 5);
    check(w_cnt0 > 255, "R8 wide carries past bit 7", w_cnt0, 256);
    // R5: chaining off holds ch1
    wr(4, 0);
    repeat (1200) @(negedge clk);
    // R2: other selects, slow tick on ch2
    wr(4, 1); wr(0, 2); wr(2, 4);
    repeat (2000) @(negedge clk);
    wr(0, 3); wr(2, 3);
    repeat (1500) @(negedge clk);
    // R3: disable ch2
    wr(3, 3);
    repeat (500) @(negedge clk);
    // R2: code 6 gives no pulse
    wr(0, 6); wr(2, 7); wr(3, 7);
    repeat (300) @(negedge clk);
    wr(0, 0); wr(2, 0);
    repeat (700) @(negedge clk);
    // R6 mid-run
    wr(5, 1);
    check(cnt0 == 0 && cnt1 == 0 && cnt2 == 0 && tioa0 == 0, "R6 sync mid-run", count_all, 0);
    repeat (600) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule